// File: doc/BRIEF.md
# Variable Pulse Width Bus Symbol Receiver

This block sits behind the receive pin of a single-wire, variable-pulse-width serial bus. It takes the raw line level (1 = active, 0 = passive) and passes it through a two-stage synchronizer and a short glitch filter. It then times every pulse between two accepted level changes, counting in ticks of a prescaled clock (nominally one microsecond). When a pulse ends, the block looks at two things: the pulse width, and whether the level was active or passive. A set of contiguous, gap-free width windows turns these into one symbol. A passive level that lasts long enough produces end-of-frame and inter-frame-space symbols by time-out, without waiting for a further edge.

Each decoded symbol appears on a 3-bit code with a one-cycle valid strobe, plus an error flag for malformed pulses. Higher layers such as byte assembly and CRC use this stream.

The control machine has three states:
- `ST_HUNT_IDLE` (after reset) moves to `ST_HUNT_SOF` when the inter-frame-space time-out fires.
- `ST_HUNT_SOF` moves to `ST_IN_FRAME` when an active start-of-frame pulse ends.
- `ST_IN_FRAME` moves to `ST_HUNT_SOF` on the inter-frame-space time-out.
- `ST_IN_FRAME` moves to `ST_HUNT_IDLE` on any invalid pulse.

Top module: `vpw_symbol_rx`

## Requirements
- R1: After reset `sym_valid_o` and `err_o` are 0. No symbol is reported until the line has been passive for `W_IFS` ticks and an active pulse in the start-of-frame window has then ended; that pulse itself is reported as SOF. Symbol codes on `sym_o`: 0 INVALID, 1 BIT0, 2 BIT1, 3 SOF, 4 EOD, 5 EOF, 6 IFS.
- R2: Inside a frame, a passive pulse of width w ticks is reported as:
  - INVALID when w < `W_SHORT_MIN`;
  - BIT0 when `W_SHORT_MIN` <= w < `W_SPLIT`;
  - BIT1 when `W_SPLIT` <= w < `W_LONG_MAX`;
  - EOD when `W_LONG_MAX` <= w < `W_SOF_MAX`;
  - INVALID when `W_SOF_MAX` <= w < `W_EOF`.
- R3: Inside a frame, an active pulse is reported with the opposite bit sense:
  - BIT1 when `W_SHORT_MIN` <= w < `W_SPLIT`;
  - BIT0 when `W_SPLIT` <= w < `W_LONG_MAX`;
  - SOF when `W_LONG_MAX` <= w < `W_SOF_MAX`;
  - INVALID when w < `W_SHORT_MIN` or w >= `W_SOF_MAX`.
- R4: Inside a frame, a passive level reports EOF when it reaches `W_EOF` ticks. If it reaches `W_IFS` ticks it also reports IFS and returns to hunting for SOF. When such a passive pulse ends, no edge symbol is reported for it.
- R5: An INVALID symbol is reported with `err_o` = 1 (and `err_o` is 0 for every other symbol). After it, the block ignores pulses until the R1 sequence is seen again.
- R6: A line excursion lasting fewer than `FILT_LEN` clock cycles is ignored. It neither splits nor ends the pulse being timed.
- R7: The width of a pulse held for N clock cycles is floor((N-1)/`TICK_DIV`) ticks. An edge-ended symbol's strobe is high for exactly one cycle, `FILT_LEN`+3 rising clock edges after the line change that ends the pulse.
- R8: The pulse counter saturates at `W_IFS` ticks. An active pulse far longer than the counter's range is still reported as INVALID, not as a wrapped width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw bus level, 1 = active, 0 = passive |
| sym_valid_o | output | 1 | One-cycle strobe: a symbol is on `sym_o` |
| sym_o | output | 3 | Symbol code (see R1) |
| err_o | output | 1 | Set with the strobe when the symbol is INVALID |

## Verification
A symbol produced by an edge has a fixed delay: it must appear exactly `FILT_LEN`+3 rising edges after the line change that ended the pulse. The bench records the cycle number of every line change it drives. For each strobe that is not EOF or IFS, it checks that distance. Time-out symbols are not tied to an edge, so they are checked only for their order in the expected queue. Pulse lengths are driven as 4w+2 cycles, so each measured width lands exactly on w ticks and the window boundaries can be hit exactly. The bench checks the queue for leftovers only after a long passive stretch, once every pending symbol must already have appeared.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;

    typedef enum logic [2:0] {
        SYM_INVALID = 3'd0,
        SYM_BIT0    = 3'd1,
        SYM_BIT1    = 3'd2,
        SYM_SOF     = 3'd3,
        SYM_EOD     = 3'd4,
        SYM_EOF     = 3'd5,
        SYM_IFS     = 3'd6
    } sym_e;

    typedef enum logic [1:0] {
        ST_HUNT_IDLE = 2'd0,
        ST_HUNT_SOF  = 2'd1,
        ST_IN_FRAME  = 2'd2
    } rx_state_e;

endpackage

// File: rtl/vpw_line_filter.sv
module vpw_line_filter #(
    parameter int FILT_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic edge_o
);
    localparam int RW = (FILT_LEN > 1) ? $clog2(FILT_LEN + 1) : 1;

    logic          s1_q;
    logic          s2_q;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            run_q  <= '0;
            lvl_o  <= 1'b0;
            edge_o <= 1'b0;
        end else begin
            s1_q   <= line_i;
            s2_q   <= s1_q;
            edge_o <= 1'b0;
            if (s2_q == lvl_o) begin
                run_q <= '0;
            end else if (run_q == RW'(FILT_LEN - 1)) begin
                lvl_o  <= s2_q;
                edge_o <= 1'b1;
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    generate
        if (FILT_LEN >= 2) begin : g_filt_chk
            // R6: accepted level must have been seen on two consecutive samples
            assert_glitch_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(lvl_o) |-> ($past(s2_q) == lvl_o && $past(s2_q, 2) == lvl_o));
        end
    endgenerate

endmodule

// File: rtl/vpw_pulse_timer.sv
module vpw_pulse_timer #(
    parameter int TICK_DIV = 50,
    parameter int W_EOF    = 280,
    parameter int W_IFS    = 300,
    parameter int CW       = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          passive_i,
    output logic [CW-1:0] cnt_o,
    output logic          eof_o,
    output logic          ifs_o
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [PW-1:0] presc_q;
    logic          tick;
    logic          step;

    assign tick = (presc_q == PW'(TICK_DIV - 1));
    assign step = !clr_i && tick && (cnt_o != CW'(W_IFS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            cnt_o   <= '0;
        end else if (clr_i) begin
            presc_q <= '0;
            cnt_o   <= '0;
        end else if (tick) begin
            presc_q <= '0;
            if (cnt_o != CW'(W_IFS)) cnt_o <= cnt_o + 1'b1;
        end else begin
            presc_q <= presc_q + 1'b1;
        end
    end

    assign eof_o = step && passive_i && (cnt_o == CW'(W_EOF - 1));
    assign ifs_o = step && passive_i && (cnt_o == CW'(W_IFS - 1));

    // R7: an accepted edge restarts the width measurement
    assert_clear_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_o == '0);
    // R8: once saturated the count holds until the next edge
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && cnt_o == CW'(W_IFS)) |=> cnt_o == CW'(W_IFS));
    // R4: edge and time-out events never coincide
    assert_single_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_i, eof_o, ifs_o}));

endmodule

// File: rtl/vpw_window_decode.sv
module vpw_window_decode
    import vpw_rx_pkg::*;
#(
    parameter int CW          = 9,
    parameter int W_SHORT_MIN = 34,
    parameter int W_SPLIT     = 96,
    parameter int W_LONG_MAX  = 163,
    parameter int W_SOF_MAX   = 239,
    parameter int W_EOF       = 280
) (
    input  logic          active_i,
    input  logic [CW-1:0] width_i,
    output sym_e          sym_o,
    output logic          emit_o
);
    always_comb begin
        emit_o = 1'b1;
        sym_o  = SYM_INVALID;
        if (width_i < CW'(W_SHORT_MIN)) begin
            sym_o = SYM_INVALID;
        end else if (width_i < CW'(W_SPLIT)) begin
            sym_o = active_i ? SYM_BIT1 : SYM_BIT0;
        end else if (width_i < CW'(W_LONG_MAX)) begin
            sym_o = active_i ? SYM_BIT0 : SYM_BIT1;
        end else if (width_i < CW'(W_SOF_MAX)) begin
            sym_o = active_i ? SYM_SOF : SYM_EOD;
        end else if (!active_i && width_i >= CW'(W_EOF)) begin
            emit_o = 1'b0;
        end
    end
endmodule

// File: rtl/vpw_symbol_rx.sv
module vpw_symbol_rx
    import vpw_rx_pkg::*;
#(
    parameter int TICK_DIV    = 50,
    parameter int FILT_LEN    = 2,
    parameter int W_SHORT_MIN = 34,
    parameter int W_SPLIT     = 96,
    parameter int W_LONG_MAX  = 163,
    parameter int W_SOF_MAX   = 239,
    parameter int W_EOF       = 280,
    parameter int W_IFS       = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    output logic       sym_valid_o,
    output logic [2:0] sym_o,
    output logic       err_o
);
    localparam int CW = $clog2(W_IFS + 1);

    logic          lvl;
    logic          edge_seen;
    logic [CW-1:0] width;
    logic          eof_hit;
    logic          ifs_hit;
    sym_e          cls;
    logic          cls_emit;

    rx_state_e state_q;
    rx_state_e state_d;
    logic      out_v;
    sym_e      out_s;

    vpw_line_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .lvl_o  (lvl),
        .edge_o (edge_seen)
    );

    vpw_pulse_timer #(
        .TICK_DIV (TICK_DIV),
        .W_EOF    (W_EOF),
        .W_IFS    (W_IFS),
        .CW       (CW)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (edge_seen),
        .passive_i (!lvl),
        .cnt_o     (width),
        .eof_o     (eof_hit),
        .ifs_o     (ifs_hit)
    );

    // the pulse that just ended has the opposite level of the new one
    vpw_window_decode #(
        .CW          (CW),
        .W_SHORT_MIN (W_SHORT_MIN),
        .W_SPLIT     (W_SPLIT),
        .W_LONG_MAX  (W_LONG_MAX),
        .W_SOF_MAX   (W_SOF_MAX),
        .W_EOF       (W_EOF)
    ) u_decode (
        .active_i (!lvl),
        .width_i  (width),
        .sym_o    (cls),
        .emit_o   (cls_emit)
    );

    always_comb begin
        state_d = state_q;
        out_v   = 1'b0;
        out_s   = SYM_INVALID;
        unique case (state_q)
            ST_HUNT_IDLE: begin
                if (ifs_hit) state_d = ST_HUNT_SOF;
            end
            ST_HUNT_SOF: begin
                if (edge_seen && !lvl && cls_emit && cls == SYM_SOF) begin
                    state_d = ST_IN_FRAME;
                    out_v   = 1'b1;
                    out_s   = SYM_SOF;
                end
            end
            ST_IN_FRAME: begin
                if (edge_seen && cls_emit) begin
                    out_v = 1'b1;
                    out_s = cls;
                    if (cls == SYM_INVALID) state_d = ST_HUNT_IDLE;
                end else if (eof_hit) begin
                    out_v = 1'b1;
                    out_s = SYM_EOF;
                end else if (ifs_hit) begin
                    out_v   = 1'b1;
                    out_s   = SYM_IFS;
                    state_d = ST_HUNT_SOF;
                end
            end
            default: state_d = ST_HUNT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_valid_o <= 1'b0;
            sym_o       <= 3'd0;
            err_o       <= 1'b0;
        end else begin
            sym_valid_o <= out_v;
            sym_o       <= out_s;
            err_o       <= out_v && (out_s == SYM_INVALID);
        end
    end

    // R1: apart from the opening SOF, symbols only come from inside a frame
    assert_frame_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid_o && sym_o != SYM_SOF) |-> $past(state_q) == ST_IN_FRAME);
    // R5: error flag only accompanies a strobe
    assert_err_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> sym_valid_o);
    // R5: an invalid pulse drops the receiver back to hunting for idle
    assert_resync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid_o && err_o) |-> state_q == ST_HUNT_IDLE);
    // R7: strobe lasts a single cycle
    assert_one_cycle_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_o |=> !sym_valid_o);

endmodule

// File: tb/vpw_symbol_rx_bench.sv
module vpw_symbol_rx_bench;
    localparam int DIV  = 4;
    localparam int FL   = 2;
    localparam int WA   = 34;
    localparam int WB   = 96;
    localparam int WC   = 163;
    localparam int WD   = 239;
    localparam int WEOF = 280;
    localparam int WIFS = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line = 1'b0;
    logic       sv;
    logic [2:0] so;
    logic       eo;

    always #10 clk = ~clk;

    vpw_symbol_rx #(
        .TICK_DIV(DIV), .FILT_LEN(FL), .W_SHORT_MIN(WA), .W_SPLIT(WB),
        .W_LONG_MAX(WC), .W_SOF_MAX(WD), .W_EOF(WEOF), .W_IFS(WIFS)
    ) u_vpw_symbol_rx (
        .clk(clk), .rst_n(rst_n), .line_i(line),
        .sym_valid_o(sv), .sym_o(so), .err_o(eo)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int last_tog = 0;
    int mode = 0;           // 0 hunt idle, 1 hunt SOF, 2 in frame
    logic [3:0] exp_q[$];
    logic [3:0] got;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int classify(input bit act, input int w);
        if (w < WA) return 0;
        if (w < WB) return act ? 2 : 1;
        if (w < WC) return act ? 1 : 2;
        if (w < WD) return act ? 3 : 4;
        if (!act && w >= WEOF) return -1;
        return 0;
    endfunction

    task automatic push(input int code);
        exp_q.push_back({code == 0, 3'(code)});
    endtask

    task automatic model(input bit act, input int w);
        int c;
        c = classify(act, w);
        if (!act && w >= WEOF) begin
            if (mode == 2) push(5);
            if (w >= WIFS) begin
                if (mode == 2) push(6);
                mode = 1;
            end
        end else if (mode == 2) begin
            push(c);
            if (c == 0) mode = 0;
        end else if (mode == 1 && act && c == 3) begin
            push(3);
            mode = 2;
        end
    endtask

    task automatic drive(input bit l, input int n);
        if (line != l) last_tog = cyc;
        line = l;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit act, input int w);
        model(act, w);
        drive(act, 4 * w + 2);
    endtask

    task automatic gpulse(input bit act, input int w, input int at);
        model(act, w);
        drive(act, at);
        drive(!act, 1);
        drive(act, 4 * w + 2 - at - 1);
    endtask

    task automatic drained(input string req);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic frame_start();
        pulse(1'b1, WC + 10);
    endtask

    always @(negedge clk) begin
        if (rst_n && sv) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 R5 unexpected symbol", int'(so), -1);
            end else begin
                got = exp_q.pop_front();
                if (got[2:0] == 3'd5 || got[2:0] == 3'd6)
                    chk({eo, so} == got, "R4 time-out symbol", int'({eo, so}), int'(got));
                else if (got[2:0] == 3'd0)
                    chk({eo, so} == got, "R5 invalid symbol", int'({eo, so}), int'(got));
                else
                    chk({eo, so} == got, "R2 R3 window decode", int'({eo, so}), int'(got));
                if (got[2:0] != 3'd5 && got[2:0] != 3'd6)
                    chk(cyc - last_tog == FL + 3, "R7 strobe latency", cyc - last_tog, FL + 3);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc == 190000) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd77215));
        repeat (3) @(negedge clk);
        chk(sv == 1'b0 && eo == 1'b0, "R1 reset outputs", int'({sv, eo}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sv == 1'b0, "R1 after release", int'(sv), 0);

        // R1: ignored before idle, ignored non-SOF while hunting
        pulse(1'b1, 200);
        pulse(1'b0, 320);
        drained("R1 nothing before sync");
        pulse(1'b1, 100);
        pulse(1'b0, 50);
        pulse(1'b1, WD - 1);          // SOF upper edge
        // R2 R3 boundaries
        pulse(1'b0, WA);      pulse(1'b1, WA);
        pulse(1'b0, WB - 1);  pulse(1'b1, WB - 1);
        pulse(1'b0, WB);      pulse(1'b1, WB);
        pulse(1'b0, WC - 1);  pulse(1'b1, WC - 1);
        pulse(1'b0, WC);      pulse(1'b1, WC);
        pulse(1'b0, WD - 1);  pulse(1'b1, 100);
        // R4 EOF only, then SOF inside the frame, then EOF+IFS
        pulse(1'b0, WEOF + 5);
        pulse(1'b1, 200);
        pulse(1'b0, 320);
        drained("R4 frame end");

        // R5 short passive, then ignored pulse, then resync
        frame_start();
        pulse(1'b0, WA - 1);
        pulse(1'b1, 100);
        pulse(1'b0, 320);
        drained("R5 resync after short passive");
        // R2 passive at SOF limit
        frame_start();
        pulse(1'b0, WD);
        pulse(1'b1, 50);
        pulse(1'b0, 320);
        // R3 short active
        frame_start();
        pulse(1'b0, 50);
        pulse(1'b1, WA - 1);
        pulse(1'b0, 320);
        // R3 active at SOF limit
        frame_start();
        pulse(1'b0, 50);
        pulse(1'b1, WD);
        pulse(1'b0, 320);
        // R2 passive just below EOF
        frame_start();
        pulse(1'b0, WEOF - 1);
        pulse(1'b1, 50);
        pulse(1'b0, 320);
        drained("R2 R3 invalid windows");

        // R6 one-cycle glitches, R8 saturation
        gpulse(1'b1, 200, 300);
        gpulse(1'b0, 60, 100);
        pulse(1'b1, 600);
        pulse(1'b0, 320);
        drained("R6 R8 glitch and saturation");

        // random frames
        for (int f = 0; f < 12; f++) begin
            int nb;
            pulse(1'b1, $urandom_range(WD - 1, WC));
            nb = 2 * (3 + $urandom_range(3, 0));
            for (int k = 0; k < nb; k++) begin
                bit act;
                int w;
                act = k[0];
                if (!act && $urandom_range(7, 0) == 0) w = $urandom_range(WD - 1, WC);
                else w = $urandom_range(WC - 1, WA);
                pulse(act, w);
            end
            pulse(1'b0, $urandom_range(330, 305));
        end
        drained("R2 R3 R4 random frames");

        drive(1'b0, 40);
        drained("R4 final drain");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule